// File: doc/BRIEF.md
# Program Sequencer with Return Stack and Vectored Interrupt

This block sequences the program of a small 4-bit controller. It holds the program counter and a shallow return stack made of three save registers, each also holding one pending-skip bit. Every clock is one instruction cycle. A decoder outside the block presents a command for the instruction at `pc_o`: advance, jump, call, return, return-then-skip or table fetch. The block then computes the address of the next instruction and whether that instruction is to be skipped.

The block also owns the interrupt path. The request input is sampled once per cycle. A falling pulse that stays low for enough samples leaves a request pending. The request is taken only when the enable bit is set and the current instruction completes as a plain sequential step. Any jump, call, return, table fetch or load-address instruction defers it. On entry the block pushes the next address together with the skip decision of the completing instruction. It then vectors to a fixed address and clears the enable. A later return restores both the address and the skip decision.

Top module: `seq_unit`

## Requirements
- R1: While `rst_ni` is low, and at the first edge after it rises with an advance command, `pc_o` starts from 0x000, `skip_o` is 0 and the interrupt enable is cleared. A qualified request is therefore not taken until the enable is written to 1.
- R2: Command advance (`cmd_i`=0) sets `pc_o` to `pc_o`+1 over the full 10-bit range. The count passes 64-word page boundaries (0x03F to 0x040) and wraps from 0x3FF to 0x000.
- R3: Command jump (`cmd_i`=1) loads `pc_o` with `target_i`.
- R4: Command call (`cmd_i`=2) loads `target_i` and pushes `pc_o`+1. Each level shifts one place down and the deepest of the three levels is lost.
- R5: Command return (`cmd_i`=3) loads `pc_o` from the top level and moves each level up one place. The bottom level keeps its value. Command return-then-skip (`cmd_i`=4) does the same and also sets `skip_o`.
- R6: An advance with `cond_skip_i`=1 raises `skip_o` for the next instruction. During that instruction `cmd_i`, `cond_skip_i` and the enable write are ignored, `pc_o` advances by 1, and `skip_o` then clears. `cond_skip_i` has no effect with transfer commands.
- R7: Command table fetch (`cmd_i`=5) pushes `pc_o`+1. It keeps `pc_o[9:8]` and replaces `pc_o[7:0]` with `tbl_lo_i`. The next cycle ignores `cmd_i`, pops back to the return address, and leaves the second level copied into the third.
- R8: `irq_ni` is sampled every cycle. A request becomes pending after one high sample followed by two low samples, and it stays pending until taken. A low of only one sample creates no request.
- R9: Taking a request pushes the next address, sets `pc_o` to 0x0FF with `skip_o`=0, and clears the enable. A further request then waits for a new enable write.
- R10: A request is not taken in a cycle whose command is jump, call, return, return-then-skip or table fetch, in the table pop cycle, or in an advance with `ld_addr_i`=1. It is taken at the first plain advance or skipped instruction that follows.
- R11: The skip decision of the instruction completing at the moment a request is taken is saved with the return address. The return restores it, so the instruction at the return point is skipped.
- R12: An advance with `ien_we_i`=1 writes `ien_val_i` to the enable. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one instruction cycle per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Sequencing command (0 advance, 1 jump, 2 call, 3 return, 4 return-then-skip, 5 table fetch) |
| target_i | input | 10 | Jump or call target |
| tbl_lo_i | input | 8 | Low address byte for table fetch |
| cond_skip_i | input | 1 | Skip condition of the current advance instruction was met |
| ld_addr_i | input | 1 | Current advance instruction is a load-address step in a chain |
| ien_we_i | input | 1 | Write the interrupt enable |
| ien_val_i | input | 1 | Value written to the interrupt enable |
| irq_ni | input | 1 | Interrupt request, active-low pulse |
| pc_o | output | 10 | Address of the current instruction |
| skip_o | output | 1 | Current instruction is skipped |

## Verification
The bench uses the default build: a 10-bit counter, three stack levels, an 8-bit table byte, a two-sample qualifier and vector 0x0FF. At this width every program address is reachable in a short run. The bench sweeps the full advance range, including page crossings and the top wraparound, and sweeps jumps across the address space. It overflows the three-level stack and pops past its bottom, and it places interrupt pulses against chains of transfers and load-address steps. Each case produces an exact address sequence that the bench derives from the requirements.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned CMD_W = 3;
  typedef enum logic [CMD_W-1:0] {
    CMD_NEXT  = 3'd0,
    CMD_JUMP  = 3'd1,
    CMD_CALL  = 3'd2,
    CMD_RET   = 3'd3,
    CMD_RETSK = 3'd4,
    CMD_TABLE = 3'd5
  } seq_cmd_e;
endpackage

// File: rtl/seq_irq_qual.sv
module seq_irq_qual #(
  parameter int unsigned QUAL = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_ni,
  input  logic ack_i,
  output logic pend_o
);
  logic [QUAL:0] smp_q;
  logic          pending_q;
  logic          hit;

  // oldest sample high, the QUAL newer ones low
  assign hit    = smp_q[QUAL] & ~(|smp_q[QUAL-1:0]);
  assign pend_o = pending_q | hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q     <= '0;
      pending_q <= 1'b0;
    end else begin
      smp_q <= {smp_q[QUAL-1:0], irq_ni};
      if (ack_i)    pending_q <= 1'b0;
      else if (hit) pending_q <= 1'b1;
    end
  end
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int unsigned W   = 10,
  parameter int unsigned LVL = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_addr_i,
  input  logic         push_skp_i,
  output logic [W-1:0] top_addr_o,
  output logic         top_skp_o
);
  logic [W-1:0] addr_q [LVL];
  logic         skp_q  [LVL];

  for (genvar i = 0; i < LVL; i++) begin : g_lvl
    logic [W-1:0] up_addr;
    logic         up_skp;
    logic [W-1:0] dn_addr;
    logic         dn_skp;
    if (i == 0) begin : g_top
      assign up_addr = push_addr_i;
      assign up_skp  = push_skp_i;
    end else begin : g_mid
      assign up_addr = addr_q[i-1];
      assign up_skp  = skp_q[i-1];
    end
    if (i == LVL - 1) begin : g_bot
      assign dn_addr = addr_q[i];   // bottom keeps its value on pop
      assign dn_skp  = skp_q[i];
    end else begin : g_inr
      assign dn_addr = addr_q[i+1];
      assign dn_skp  = skp_q[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[i] <= '0;
        skp_q[i]  <= 1'b0;
      end else if (push_i) begin
        addr_q[i] <= up_addr;
        skp_q[i]  <= up_skp;
      end else if (pop_i) begin
        addr_q[i] <= dn_addr;
        skp_q[i]  <= dn_skp;
      end
    end
  end

  assign top_addr_o = addr_q[0];
  assign top_skp_o  = skp_q[0];
endmodule

// File: rtl/seq_unit.sv
module seq_unit #(
  parameter int unsigned PC_W    = 10,
  parameter int unsigned LVL     = 3,
  parameter int unsigned TBL_W   = 8,
  parameter int unsigned QUAL    = 2,
  parameter int unsigned IRQ_VEC = 'h0FF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [seq_pkg::CMD_W-1:0] cmd_i,
  input  logic [PC_W-1:0]          target_i,
  input  logic [TBL_W-1:0]         tbl_lo_i,
  input  logic                     cond_skip_i,
  input  logic                     ld_addr_i,
  input  logic                     ien_we_i,
  input  logic                     ien_val_i,
  input  logic                     irq_ni,
  output logic [PC_W-1:0]          pc_o,
  output logic                     skip_o
);
  import seq_pkg::*;

  localparam int unsigned HI_W = PC_W - TBL_W;
  localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VEC);

  logic [PC_W-1:0] pc_q, pc_n, pc_inc;
  logic            skip_q, skip_n;
  logic            tbl_busy_q, tbl_busy_n;
  logic            ien_q;
  logic            push, pop, push_skp;
  logic [PC_W-1:0] push_addr;
  logic [PC_W-1:0] top_addr;
  logic            top_skp;
  logic            adv, ien_wr, pend, irq_ack;
  seq_cmd_e        cmd;

  assign cmd    = seq_cmd_e'(cmd_i);
  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    pc_n       = pc_q;
    skip_n     = skip_q;
    tbl_busy_n = 1'b0;
    push       = 1'b0;
    pop        = 1'b0;
    push_addr  = pc_inc;
    push_skp   = 1'b0;
    adv        = 1'b0;
    ien_wr     = 1'b0;
    if (tbl_busy_q) begin
      pop    = 1'b1;
      pc_n   = top_addr;
      skip_n = top_skp;
    end else if (skip_q) begin
      pc_n   = pc_inc;
      skip_n = 1'b0;
      adv    = 1'b1;
    end else begin
      skip_n = 1'b0;
      case (cmd)
        CMD_JUMP: pc_n = target_i;
        CMD_CALL: begin
          push = 1'b1;
          pc_n = target_i;
        end
        CMD_RET: begin
          pop    = 1'b1;
          pc_n   = top_addr;
          skip_n = top_skp;
        end
        CMD_RETSK: begin
          pop    = 1'b1;
          pc_n   = top_addr;
          skip_n = 1'b1;
        end
        CMD_TABLE: begin
          push       = 1'b1;
          pc_n       = {pc_q[PC_W-1 -: HI_W], tbl_lo_i};
          tbl_busy_n = 1'b1;
        end
        default: begin
          pc_n   = pc_inc;
          skip_n = cond_skip_i;
          adv    = ~ld_addr_i;
          ien_wr = ien_we_i;
        end
      endcase
    end
    irq_ack = adv & pend & ien_q;
    if (irq_ack) begin
      push      = 1'b1;
      push_addr = pc_n;
      push_skp  = skip_n;
      pc_n      = VEC;
      skip_n    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      skip_q     <= 1'b0;
      tbl_busy_q <= 1'b0;
      ien_q      <= 1'b0;
    end else begin
      pc_q       <= pc_n;
      skip_q     <= skip_n;
      tbl_busy_q <= tbl_busy_n;
      if (irq_ack)     ien_q <= 1'b0;
      else if (ien_wr) ien_q <= ien_val_i;
    end
  end

  seq_ret_stack #(.W(PC_W), .LVL(LVL)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_addr_i (push_addr),
    .push_skp_i  (push_skp),
    .top_addr_o  (top_addr),
    .top_skp_o   (top_skp)
  );

  seq_irq_qual #(.QUAL(QUAL)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_ni (irq_ni),
    .ack_i  (irq_ack),
    .pend_o (pend)
  );

  assign pc_o   = pc_q;
  assign skip_o = skip_q;
endmodule

// File: rtl/seq_unit_chk.sv
module seq_unit_chk #(
  parameter int unsigned PC_W    = 10,
  parameter int unsigned TBL_W   = 8,
  parameter int unsigned IRQ_VEC = 'h0FF
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [seq_pkg::CMD_W-1:0] cmd_i,
  input logic [TBL_W-1:0]          tbl_lo_i,
  input logic                      ld_addr_i,
  input logic [PC_W-1:0]           pc_o,
  input logic                      skip_o,
  input logic                      irq_ack,
  input logic                      tbl_busy_q,
  input logic                      ien_q
);
  import seq_pkg::*;
  localparam int unsigned HI_W = PC_W - TBL_W;

  logic plain;
  assign plain = !tbl_busy_q && !skip_o;

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plain && cmd_i == CMD_NEXT && !irq_ack) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  a_r5_retsk_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plain && cmd_i == CMD_RETSK) |=> skip_o);

  a_r6_skip_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> !skip_o);

  a_r7_table_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plain && cmd_i == CMD_TABLE) |=>
      (pc_o[TBL_W-1:0] == $past(tbl_lo_i)) && (pc_o[PC_W-1 -: HI_W] == $past(pc_o[PC_W-1 -: HI_W])));

  a_r9_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack |=> (pc_o == PC_W'(IRQ_VEC)) && !skip_o && !ien_q);

  a_r10_defer_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_busy_q || (!skip_o && (cmd_i != CMD_NEXT || ld_addr_i))) |-> !irq_ack);
endmodule

bind seq_unit seq_unit_chk #(.PC_W(PC_W), .TBL_W(TBL_W), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_i      (cmd_i),
  .tbl_lo_i   (tbl_lo_i),
  .ld_addr_i  (ld_addr_i),
  .pc_o       (pc_o),
  .skip_o     (skip_o),
  .irq_ack    (irq_ack),
  .tbl_busy_q (tbl_busy_q),
  .ien_q      (ien_q)
);

// File: tb/seq_unit_bench.sv
module seq_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [9:0] target_i = '0;
  logic [7:0] tbl_lo_i = '0;
  logic       cond_skip_i = 1'b0, ld_addr_i = 1'b0;
  logic       ien_we_i = 1'b0, ien_val_i = 1'b0;
  logic       irq_ni = 1'b1;
  logic [9:0] pc_o;
  logic       skip_o;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [2:0] NX = 3'd0, JP = 3'd1, CL = 3'd2, RT = 3'd3, RS = 3'd4, TB = 3'd5;

  always #2 clk_i = ~clk_i;

  seq_unit u_seq_unit (
    .clk_i, .rst_ni, .cmd_i, .target_i, .tbl_lo_i, .cond_skip_i,
    .ld_addr_i, .ien_we_i, .ien_val_i, .irq_ni, .pc_o, .skip_o
  );

  task automatic step(input logic [2:0] c, input logic [9:0] t = '0,
                      input logic irq = 1'b1, input logic cs = 1'b0,
                      input logic la = 1'b0, input logic we = 1'b0,
                      input logic wv = 1'b0, input logic [7:0] tb = '0);
    cmd_i = c; target_i = t; irq_ni = irq; cond_skip_i = cs;
    ld_addr_i = la; ien_we_i = we; ien_val_i = wv; tbl_lo_i = tb;
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string req, input logic [9:0] epc, input logic esk);
    n_run++;
    if (pc_o !== epc || skip_o !== esk) begin
      n_fail++;
      $display("FAIL %s: pc=%h skip=%b expected pc=%h skip=%b", req, pc_o, skip_o, epc, esk);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    cmd_i = NX; irq_ni = 1'b1; ien_we_i = 1'b0; cond_skip_i = 1'b0; ld_addr_i = 1'b0;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R1 reset", 10'h000, 1'b0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 / R2: full advance sweep with page crossings and wrap
    do_reset();
    for (int i = 1; i <= 1025; i++) begin
      step(NX);
      chk("R2 advance", 10'((i) % 1024), 1'b0);
    end

    // R3: jump sweep
    do_reset();
    for (int t = 0; t < 1024; t += 37) begin
      step(JP, 10'(t));
      chk("R3 jump", 10'(t), 1'b0);
    end

    // R4 / R5: overflow three levels, pop past bottom
    do_reset();
    step(JP, 10'h100);
    step(CL, 10'h200); chk("R4 call", 10'h200, 1'b0);
    step(CL, 10'h300);
    step(CL, 10'h3C0);
    step(CL, 10'h010); chk("R4 call4", 10'h010, 1'b0);
    step(RT); chk("R5 ret1", 10'h3C1, 1'b0);
    step(RT); chk("R5 ret2", 10'h301, 1'b0);
    step(RT); chk("R5 ret3", 10'h201, 1'b0);
    step(RT); chk("R4 oldest lost", 10'h201, 1'b0);

    // R5 return-then-skip, R6 skipped instruction ignores command
    do_reset();
    step(CL, 10'h050);
    step(RS); chk("R5 retsk", 10'h001, 1'b1);
    step(JP, 10'h2AA); chk("R6 skipped jump", 10'h002, 1'b0);
    step(NX, '0, 1'b1, 1'b1); chk("R6 skip set", 10'h003, 1'b1);
    step(CL, 10'h155, 1'b1, 1'b1); chk("R6 skipped call", 10'h004, 1'b0);
    step(JP, 10'h123, 1'b1, 1'b1); chk("R6 cond on jump", 10'h123, 1'b0);

    // R7 table fetch
    do_reset();
    step(CL, 10'h111);
    step(CL, 10'h222);
    step(TB, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3A); chk("R7 table addr", 10'h23A, 1'b0);
    step(JP, 10'h3FF); chk("R7 table return", 10'h223, 1'b0);
    step(RT); chk("R7 pop1", 10'h112, 1'b0);
    step(RT); chk("R7 pop2", 10'h001, 1'b0);
    step(RT); chk("R7 level copy", 10'h001, 1'b0);

    // R1 / R8 / R12: pending held while disabled, taken after enable
    do_reset();
    step(NX, '0, 1'b1);
    step(NX, '0, 1'b0);
    step(NX, '0, 1'b0);
    step(NX); step(NX); chk("R1 no vector while disabled", 10'h005, 1'b0);
    step(NX, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1); chk("R12 write", 10'h006, 1'b0);
    step(NX); chk("R8 pending kept", 10'h0FF, 1'b0);
    step(RT); chk("R9 return", 10'h007, 1'b0);
    // R9: enable cleared by entry
    step(NX, '0, 1'b0);
    step(NX, '0, 1'b0);
    step(NX); step(NX); chk("R9 enable cleared", 10'h00B, 1'b0);
    step(NX, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step(NX); chk("R9 reenter", 10'h0FF, 1'b0);

    // R8: one-sample low pulse
    do_reset();
    step(NX, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step(NX, '0, 1'b0);
    step(NX, '0, 1'b1);
    step(NX); step(NX); step(NX); chk("R8 short pulse", 10'h006, 1'b0);

    // R10: deferral through transfer and load-address chain
    do_reset();
    step(NX, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step(NX, '0, 1'b0);
    step(NX, '0, 1'b0);
    step(JP, 10'h080); chk("R10 jump defer", 10'h080, 1'b0);
    step(JP, 10'h090); chk("R10 jump chain", 10'h090, 1'b0);
    step(NX, '0, 1'b1, 1'b0, 1'b1); chk("R10 ld_addr defer", 10'h091, 1'b0);
    step(NX); chk("R10 taken", 10'h0FF, 1'b0);
    step(RT); chk("R10 return", 10'h092, 1'b0);

    // R11: skip state saved and restored
    do_reset();
    step(NX, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step(NX, '0, 1'b0);
    step(NX, '0, 1'b0);
    step(NX, '0, 1'b1, 1'b1); chk("R11 entry", 10'h0FF, 1'b0);
    step(NX); chk("R11 isr", 10'h100, 1'b0);
    step(RT); chk("R11 restored", 10'h004, 1'b1);
    step(JP, 10'h333); chk("R11 skipped", 10'h005, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule